// File: doc/BRIEF.md
# Eight-Input Programmable Interrupt Controller

The block gathers eight interrupt inputs into a single request line for a processor. Software programs it through a byte-wide register port with one address bit. Address 0 takes the start-of-initialization word and all operation commands. Address 1 takes the rest of the initialization words and otherwise holds the interrupt mask. The block keeps a pending-request register and an in-service register. A rising edge on an input raises a request. An acknowledge strobe moves the winning request into service and returns a vector byte.

The register port has no back-pressure. A write is taken on every clock edge where `bus_wr` is high. `bus_rdata` follows `bus_addr` combinationally and reading has no side effect. The vector output is a one-cycle valid pulse that follows each acknowledge strobe. It cannot be stalled, so the consumer must capture it in that cycle. Words that select cascading, level triggering, special masking or priority rotation are accepted and have no effect.

Top module: `irq_ctl8`

## Requirements
- R1: After reset the mask, request and in-service registers are zero and `irq_out` and `cmd_err` are low. Reads of address 0 use poll format. The vector base is 0 when `SECONDARY` is 0.
- R2: An input going from 0 to 1 sets its request bit on the next clock edge. An input held high does not set the bit again once it has been cleared.
- R3: `irq_out` is high exactly when some request bit is set whose mask bit is clear.
- R4: A write to address 0 with bit 4 set starts initialization. The next three writes to address 1 act as follows, and none of them changes the mask: the first stores data AND 0xF8 as the vector base, the second is discarded, and the third returns the block to normal operation.
- R5: A write to address 0 with bit 4 clear cancels any initialization in progress and is then decoded as a command.
- R6: Command 0x0A makes address 0 read the request register, and 0x0B makes it read the in-service register. Command 0x0C, which is also the reset choice, makes it read the poll byte.
- R7: The poll byte is 0x80 OR the index of the lowest set request bit, or 0x00 when no request bit is set. The mask does not affect it.
- R8: Command 0x20 clears every request bit that is also set in the in-service register, then clears the whole in-service register.
- R9: Commands 0x21 to 0x27 and 0x60 to 0x67 clear the request bit and the in-service bit at the index given by command bits 2:0.
- R10: Commands 0x68 and 0xC0 to 0xC7 change nothing. Any other command with bit 4 clear sets `cmd_err`, which then stays high until reset.
- R11: Outside initialization, a write to address 1 loads the mask, and a read of address 1 returns it.
- R12: On an `ack_stb` cycle, the lowest-index unmasked pending request leaves the request register and enters the in-service register. On the next cycle `vec_valid` pulses and `vec_data` is base OR index. If no request is eligible, `vec_data` is base OR 7 and neither register changes.
- R13: In a cycle where a request bit is cleared, a new rising edge on that same input leaves the bit set. When an acknowledge and a non-specific end-of-interrupt fall in the same cycle, the clearing is applied first and the acknowledged bit is then set.
- R14: With `SECONDARY` set to 1, the vector base resets to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_in | input | 8 | Interrupt inputs, rising-edge sensitive |
| irq_out | output | 1 | Interrupt request to the processor |
| ack_stb | input | 1 | Interrupt acknowledge strobe |
| vec_valid | output | 1 | Vector byte valid, one-cycle pulse |
| vec_data | output | 8 | Vector byte |
| cmd_err | output | 1 | Sticky flag for an unknown command |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a clear of a request bit and a new edge on that same input. The bench drives a specific end-of-interrupt together with a fresh rise on input 0, and expects the request bit to stay set while the in-service bit drops. The second pair is an acknowledge and a non-specific end-of-interrupt. The bench issues both together and expects the old in-service bit to be gone, the newly acknowledged bit to be in service, and the vector to name the new index.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  localparam int PIC_N  = 8;
  localparam int PIC_DW = 8;
  localparam int PIC_IW = $clog2(PIC_N);

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_MODE = 2'd3
  } seq_e;

  typedef enum logic [1:0] {
    RSEL_POLL = 2'd0,
    RSEL_REQ  = 2'd1,
    RSEL_SRV  = 2'd2
  } rsel_e;

  typedef struct packed {
    logic              clr_all;
    logic              clr_one;
    logic [PIC_IW-1:0] idx;
  } eoi_t;
endpackage

// File: rtl/pic8_prio.sv
module pic8_prio #(
  parameter int N = pic8_pkg::PIC_N,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  logic [N-1:0] below;
  logic [N-1:0] first;

  generate
    for (genvar g = 0; g < N; g++) begin : g_bit
      if (g == 0) begin : g_lo
        assign below[g] = 1'b0;
      end else begin : g_hi
        assign below[g] = below[g-1] | req[g-1];
      end
      assign first[g] = req[g] & ~below[g];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (first[i]) idx = idx | IW'(i);
    end
  end

  assign found = |req;
endmodule

// File: rtl/pic8_cmd_dec.sv
module pic8_cmd_dec
  import pic8_pkg::*;
#(
  parameter bit SECONDARY = 1'b0,
  parameter int DW = PIC_DW,
  parameter int IW = PIC_IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] base,
  output rsel_e         rsel,
  output logic          busy,
  output logic          mask_we,
  output eoi_t          eoi,
  output logic          err
);
  localparam logic [DW-1:0] BASE_RST = SECONDARY ? DW'(8) : '0;
  localparam logic [DW-1:0] BASE_KEEP = ~DW'((1 << IW) - 1);

  seq_e  seq_q;
  logic  start_w, cmd_w, cfg_w;
  logic  sel_hit, bad_cmd;
  rsel_e sel_val;

  assign start_w = wr && !addr && wdata[4];
  assign cmd_w   = wr && !addr && !wdata[4];
  assign cfg_w   = wr && addr;
  assign busy    = (seq_q != SEQ_IDLE);
  assign mask_we = cfg_w && !busy;

  always_comb begin
    sel_hit     = 1'b0;
    sel_val     = RSEL_POLL;
    bad_cmd     = 1'b0;
    eoi.clr_all = 1'b0;
    eoi.clr_one = 1'b0;
    eoi.idx     = wdata[IW-1:0];
    casez (wdata)
      8'h0A:        begin sel_hit = 1'b1; sel_val = RSEL_REQ;  end
      8'h0B:        begin sel_hit = 1'b1; sel_val = RSEL_SRV;  end
      8'h0C:        begin sel_hit = 1'b1; sel_val = RSEL_POLL; end
      8'b0010_0???: begin
        if (wdata[2:0] == 3'd0) eoi.clr_all = 1'b1;
        else                    eoi.clr_one = 1'b1;
      end
      8'b0110_0???: eoi.clr_one = 1'b1;
      8'h68:        ;
      8'b1100_0???: ;
      default:      bad_cmd = 1'b1;
    endcase
    if (!cmd_w) begin
      sel_hit     = 1'b0;
      bad_cmd     = 1'b0;
      eoi.clr_all = 1'b0;
      eoi.clr_one = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= SEQ_IDLE;
      base  <= BASE_RST;
      rsel  <= RSEL_POLL;
      err   <= 1'b0;
    end else begin
      if (start_w) begin
        seq_q <= SEQ_BASE;
      end else if (cmd_w) begin
        seq_q <= SEQ_IDLE;
      end else if (cfg_w) begin
        case (seq_q)
          SEQ_BASE: begin
            base  <= wdata & BASE_KEEP;
            seq_q <= SEQ_CASC;
          end
          SEQ_CASC: seq_q <= SEQ_MODE;
          SEQ_MODE: seq_q <= SEQ_IDLE;
          default:  seq_q <= SEQ_IDLE;
        endcase
      end
      if (sel_hit) rsel <= sel_val;
      if (bad_cmd) err <= 1'b1;
    end
  end

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  a_r4_start_enters: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> (seq_q == SEQ_BASE));
  a_r5_cmd_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_w |=> !busy);
endmodule

// File: rtl/pic8_req_bank.sv
module pic8_req_bank
  import pic8_pkg::*;
#(
  parameter int N = PIC_N,
  parameter int IW = PIC_IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  input  eoi_t          eoi,
  input  logic          take,
  input  logic [IW-1:0] take_idx,
  output logic [N-1:0]  irr,
  output logic [N-1:0]  isr
);
  logic [N-1:0] prev_q, rise, one_vec, take_vec, clr_isr, clr_irr;

  assign rise     = irq_in & ~prev_q;
  assign one_vec  = eoi.clr_one ? (N'(1) << eoi.idx) : '0;
  assign take_vec = take ? (N'(1) << take_idx) : '0;
  assign clr_isr  = eoi.clr_all ? '1 : one_vec;
  assign clr_irr  = (eoi.clr_all ? isr : one_vec) | take_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr    <= '0;
      isr    <= '0;
    end else begin
      prev_q <= irq_in;
      irr    <= (irr & ~clr_irr) | rise;
      isr    <= (isr & ~clr_isr) | take_vec;
    end
  end

  a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((irr & $past(rise)) == $past(rise)));
  a_r8_all_clears: assert property (@(posedge clk) disable iff (!rst_n)
    eoi.clr_all |=> ((isr & ~$past(take_vec)) == '0));
  a_r9_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi.clr_one && !(take && take_idx == eoi.idx)) |=> !isr[$past(eoi.idx)]);
  a_r12_take_enters: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> isr[$past(take_idx)]);
endmodule

// File: rtl/irq_ctl8.sv
module irq_ctl8
  import pic8_pkg::*;
#(
  parameter bit SECONDARY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [PIC_DW-1:0] bus_wdata,
  output logic [PIC_DW-1:0] bus_rdata,
  input  logic [PIC_N-1:0]  irq_in,
  output logic              irq_out,
  input  logic              ack_stb,
  output logic              vec_valid,
  output logic [PIC_DW-1:0] vec_data,
  output logic              cmd_err
);
  localparam int N  = PIC_N;
  localparam int DW = PIC_DW;
  localparam int IW = PIC_IW;

  logic [DW-1:0] base;
  rsel_e         rsel;
  logic          busy, mask_we;
  eoi_t          eoi;
  logic [N-1:0]  irr, isr, imr;
  logic [N-1:0]  eligible;
  logic          poll_found, take_found, take;
  logic [IW-1:0] poll_idx, take_idx;
  logic [DW-1:0] poll_word;

  pic8_cmd_dec #(.SECONDARY(SECONDARY), .DW(DW), .IW(IW)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .base(base), .rsel(rsel), .busy(busy), .mask_we(mask_we), .eoi(eoi),
    .err(cmd_err)
  );

  assign eligible = irr & ~imr;

  pic8_prio #(.N(N)) u_poll (.req(irr), .found(poll_found), .idx(poll_idx));
  pic8_prio #(.N(N)) u_pick (.req(eligible), .found(take_found), .idx(take_idx));

  assign take = ack_stb && take_found;

  pic8_req_bank #(.N(N), .IW(IW)) u_bank (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .eoi(eoi), .take(take),
    .take_idx(take_idx), .irr(irr), .isr(isr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr       <= '0;
      vec_valid <= 1'b0;
      vec_data  <= '0;
    end else begin
      if (mask_we) imr <= bus_wdata[N-1:0];
      vec_valid <= ack_stb;
      if (ack_stb) vec_data <= base | DW'(take_found ? take_idx : IW'(N - 1));
    end
  end

  always_comb begin
    poll_word = '0;
    if (poll_found) begin
      poll_word[DW-1]   = 1'b1;
      poll_word[IW-1:0] = poll_idx;
    end
  end

  always_comb begin
    if (bus_addr) begin
      bus_rdata = DW'(imr);
    end else begin
      case (rsel)
        RSEL_REQ: bus_rdata = DW'(irr);
        RSEL_SRV: bus_rdata = DW'(isr);
        default:  bus_rdata = poll_word;
      endcase
    end
  end

  assign irq_out = |eligible;

  a_r4_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(imr));
  a_r12_vec_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |=> vec_valid);
  a_r12_vec_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_stb |=> !vec_valid);
  a_r3_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> irq_out);
endmodule

// File: tb/irq_ctl8_bench.sv
`timescale 1ns/1ps
module irq_ctl8_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] irq_in = '0;
  logic       irq_out, ack_stb = 1'b0, vec_valid, cmd_err;
  logic [7:0] vec_data;
  logic       ack_s = 1'b0, vv_s, irq_s, err_s;
  logic [7:0] vd_s, rd_s;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  irq_ctl8 u_irq_ctl8 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .irq_out(irq_out), .ack_stb(ack_stb), .vec_valid(vec_valid),
    .vec_data(vec_data), .cmd_err(cmd_err)
  );

  irq_ctl8 #(.SECONDARY(1'b1)) u_irq_ctl8_sec (
    .clk(clk), .rst_n(rst_n), .bus_wr(1'b0), .bus_addr(1'b0),
    .bus_wdata(8'h00), .bus_rdata(rd_s), .irq_in(8'h00),
    .irq_out(irq_s), .ack_stb(ack_s), .vec_valid(vv_s),
    .vec_data(vd_s), .cmd_err(err_s)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h exp %02h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] low_idx(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) if (v[i]) low_idx = 8'(i);
    if (v == 0) low_idx = 8'h00;
  endfunction

  function automatic logic [7:0] poll_of(input logic [7:0] v);
    poll_of = (v == 0) ? 8'h00 : (8'h80 | low_idx(v));
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; irq_in = '0; ack_stb = 1'b0; bus_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input logic [7:0] p);
    @(negedge clk); irq_in = p;
    @(negedge clk); irq_in = '0;
  endtask

  task automatic ack();
    @(negedge clk); ack_stb = 1'b1;
    @(negedge clk); ack_stb = 1'b0;
  endtask

  task automatic read_req(output logic [7:0] d);
    wr(1'b0, 8'h0A); rd(1'b0, d);
  endtask

  task automatic read_srv(output logic [7:0] d);
    wr(1'b0, 8'h0B); rd(1'b0, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got 00 exp 01");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r, m, u, ei, es, k;
    do_reset();
    // R1 reset state
    rd(1'b0, r); chk("R1 poll", r, 8'h00);
    rd(1'b1, r); chk("R1 mask", r, 8'h00);
    chk("R1 irq", {7'd0, irq_out}, 8'h00);
    chk("R1 err", {7'd0, cmd_err}, 8'h00);
    @(negedge clk); ack_stb = 1'b1; ack_s = 1'b1;
    @(negedge clk); ack_stb = 1'b0; ack_s = 1'b0;
    chk("R12 empty vector", vec_data, 8'h07);
    chk("R14 secondary base", vd_s, 8'h0F);
    chk("R14 secondary valid", {7'd0, vv_s}, 8'h01);

    // R7 R3 R11 R6 sweep over request patterns and masks
    for (int p = 0; p < 256; p++) begin
      do_reset();
      m = 8'(p) ^ 8'h5A;
      wr(1'b1, m);
      pulse(8'(p));
      rd(1'b1, r); chk("R11 mask read", r, m);
      rd(1'b0, r); chk("R7 poll", r, poll_of(8'(p)));
      chk("R3 irq", {7'd0, irq_out}, {7'd0, |(8'(p) & ~m)});
      read_req(r); chk("R6 req select", r, 8'(p));
      wr(1'b0, 8'h0C); rd(1'b0, r); chk("R6 poll select", r, poll_of(8'(p)));
    end

    // R12 acknowledge sweep
    for (int p = 0; p < 256; p++) begin
      do_reset();
      m = 8'((p * 37) & 8'hFF);
      wr(1'b1, m);
      pulse(8'(p));
      ack();
      u = 8'(p) & ~m;
      chk("R12 valid", {7'd0, vec_valid}, 8'h01);
      if (u != 0) begin
        k = low_idx(u);
        chk("R12 vector", vec_data, k);
        read_srv(r); chk("R12 isr", r, 8'(1 << k));
        read_req(r); chk("R12 irr", r, 8'(p) & ~8'(1 << k));
      end else begin
        chk("R12 vector none", vec_data, 8'h07);
        read_srv(r); chk("R12 isr none", r, 8'h00);
        read_req(r); chk("R12 irr none", r, 8'(p));
      end
    end

    // R8 R9 R10 command sweep
    for (int v = 0; v < 256; v++) begin
      if (v[4]) continue;
      do_reset();
      pulse(8'h81);
      ack();
      wr(1'b0, 8'(v));
      ei = 8'h01; es = 8'h80;
      if (v == 8'h20) begin
        ei = 8'h00;
      end else if ((v >= 8'h21 && v <= 8'h27) || (v >= 8'h60 && v <= 8'h67)) begin
        ei = 8'h01 & ~8'(1 << (v & 7));
        es = 8'h80 & ~8'(1 << (v & 7));
      end
      k = (v == 8'h0A || v == 8'h0B || v == 8'h0C || v == 8'h20 ||
           (v >= 8'h21 && v <= 8'h27) || (v >= 8'h60 && v <= 8'h68) ||
           (v >= 8'hC0 && v <= 8'hC7)) ? 8'h00 : 8'h01;
      chk("R10 err flag", {7'd0, cmd_err}, k);
      read_srv(r); chk("R9 R8 isr after cmd", r, ei);
      read_req(r); chk("R9 R8 irr after cmd", r, es);
      chk("R10 err sticky", {7'd0, cmd_err}, k);
    end

    // R8 clears request bits that are in service
    do_reset();
    pulse(8'h01); ack(); pulse(8'h01);
    wr(1'b0, 8'h20);
    read_req(r); chk("R8 irr cleared", r, 8'h00);
    read_srv(r); chk("R8 isr cleared", r, 8'h00);

    // R2 held level does not re-request
    do_reset();
    @(negedge clk); irq_in = 8'h04;
    @(negedge clk);
    ack();
    chk("R2 vector", vec_data, 8'h02);
    repeat (3) @(negedge clk);
    read_req(r); chk("R2 held level", r, 8'h00);
    irq_in = '0;

    // R13 edge wins over clear in same cycle
    do_reset();
    pulse(8'h01); ack();
    @(negedge clk);
    irq_in = 8'h01; bus_addr = 1'b0; bus_wdata = 8'h60; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; irq_in = 8'h00;
    chk("R13 irq after edge", {7'd0, irq_out}, 8'h01);
    read_req(r); chk("R13 irr kept", r, 8'h01);
    read_srv(r); chk("R13 isr dropped", r, 8'h00);

    // R13 acknowledge with non-specific EOI in same cycle
    do_reset();
    pulse(8'h03); ack();
    @(negedge clk);
    ack_stb = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h20; bus_wr = 1'b1;
    @(negedge clk);
    ack_stb = 1'b0; bus_wr = 1'b0;
    chk("R13 vector", vec_data, 8'h01);
    read_srv(r); chk("R13 isr new", r, 8'h02);
    read_req(r); chk("R13 irr empty", r, 8'h00);

    // R4 full initialization
    do_reset();
    wr(1'b1, 8'h33);
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h4D);
    rd(1'b1, r); chk("R4 mask kept 1", r, 8'h33);
    wr(1'b1, 8'h77);
    wr(1'b1, 8'h01);
    rd(1'b1, r); chk("R4 mask kept 2", r, 8'h33);
    chk("R4 no err", {7'd0, cmd_err}, 8'h00);
    wr(1'b1, 8'h0C);
    rd(1'b1, r); chk("R4 mask after init", r, 8'h0C);
    pulse(8'h10); ack();
    chk("R4 base vector", vec_data, 8'h4C);

    // R5 cancelled initialization
    wr(1'b0, 8'h13);
    wr(1'b1, 8'h90);
    wr(1'b0, 8'h0B);
    wr(1'b1, 8'h22);
    rd(1'b1, r); chk("R5 mask after cancel", r, 8'h22);
    rd(1'b0, r); chk("R5 cmd decoded", r, 8'h10);
    pulse(8'h01); ack();
    chk("R5 new base", vec_data, 8'h90);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule